// File: doc/BRIEF.md
# Link Frame Transmit Scheduler

This block sits between a host-filled transmit buffer and the 32-bit word interface of a serial transceiver on a Fibre-Channel-style link. Every cycle it decides what the line carries. The choices are an acknowledge frame, the next frame of a counted data burst, or idle ordered sets when nothing is pending. Data frames take their payload words straight from the buffer's read stream. A CRC-32 over the header and payload is computed as the words go out and is appended before the end-of-frame ordered set.

Two plain level inputs control the block. A rising edge on the acknowledge enable queues one acknowledge frame. A rising edge on the data enable arms a burst of a preset number of data frames. The data enable must fall and rise again before another burst can start. A one-cycle done pulse marks the end of each acknowledge frame and the end of the last frame of a burst.

Both data paths are valid/ready streams. The transmit side holds its word, its control flags and its valid unchanged while the transceiver withholds ready. The buffer side is only asked for a word while a payload word can actually be passed on, so `buf_ready` is never high without `tx_ready`. A buffer source must keep its word and its valid until the word is taken. If the buffer runs dry in the middle of a payload, the block drops `tx_valid` for those cycles instead of inserting any other word.

Top module: `link_tx_scheduler`

## Requirements
- R1: While no frame is pending or in progress, every word offered is the idle ordered set 32'hB595_95BC with `tx_ctrl` = 4'b0001, and `tx_valid` is high. Bit i of `tx_ctrl` flags the byte in bits [8i+7:8i] as a control character.
- R2: A frame is the start ordered set 32'h3636_B5BC, one header word, the payload words, one CRC word and the end ordered set 32'h9595_75BC. Both ordered sets carry `tx_ctrl` = 4'b0001 and all other frame words carry 4'b0000. A data frame's payload is exactly `frame_words` buffer words in the order they were read, sampled when the frame starts. A value of 0 gives a data frame with no payload.
- R3: The CRC word is CRC-32 with polynomial 32'h04C11DB7. The register starts at all ones. Each word is shifted in most significant bit first, the header first and then the payload. The register is inverted on output.
- R4: A rising edge of `data_en` while no burst is active, with `burst_frames` = N > 0, sends N data frames. Their header words are {8'h08, 8'h00, 16-bit frame index}, with the index counting 0 to N-1. When N = 0, no frame is sent.
- R5: `burst_done` is high for exactly the cycle in which the end ordered set of a burst's last frame is accepted. Rising edges of `data_en` during an active burst are ignored. Holding `data_en` high after a burst starts nothing new.
- R6: A rising edge of `ack_en` queues one acknowledge frame, whose header is 32'hC000_0000 and which has no payload. `ack_done` is high for exactly the cycle in which that frame's end ordered set is accepted.
- R7: A queued acknowledge frame is sent before the next data frame of an active burst. It never breaks into a frame that is already in progress.
- R8: At least two idle words are accepted between the end of one frame and the start of the next, and also after reset.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_ctrl` and `tx_valid` hold their values into the next cycle. `buf_ready` is only high when `tx_ready` is high. `tx_valid` is low only during payload while `buf_valid` is low.
- R10: During reset the block offers idle with `tx_valid` high, `buf_ready` low and both done pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_en | input | 1 | Rising edge queues an acknowledge frame |
| data_en | input | 1 | Rising edge arms a data burst |
| burst_frames | input | CNT_W | Number of data frames per burst, sampled at arming |
| frame_words | input | LEN_W | Payload words per data frame, sampled at frame start |
| buf_data | input | 32 | Transmit buffer read word |
| buf_valid | input | 1 | Buffer word available |
| buf_ready | output | 1 | Buffer word taken this cycle when valid |
| tx_data | output | 32 | Word toward the transceiver |
| tx_ctrl | output | 4 | Per-byte control-character flags |
| tx_valid | output | 1 | Word on `tx_data` is valid |
| tx_ready | input | 1 | Transceiver accepts the word |
| burst_done | output | 1 | Pulse with the last end ordered set of a burst |
| ack_done | output | 1 | Pulse with the end ordered set of an acknowledge frame |

## Verification
The hardest case to reach from the ports is an acknowledge request that arrives while a data frame of a burst is on the line, with both streams stalling at random. Only then are R7 and the hold rules tested together. To get there, the stimulus arms a long burst with random back-pressure on both streams. It waits until the monitor has seen the first frame's start ordered set, and then pulses the acknowledge enable. The scoreboard expects the order: data frame 0, the acknowledge frame, then the remaining data frames. It also checks that every frame stays whole and that the idle gap rule holds.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF,
    ST_HDR,
    ST_PAY,
    ST_CRC,
    ST_EOF
  } fr_state_e;

  localparam logic [31:0] OS_IDLE  = 32'hB595_95BC;
  localparam logic [31:0] OS_SOF   = 32'h3636_B5BC;
  localparam logic [31:0] OS_EOF   = 32'h9595_75BC;
  localparam logic [3:0]  CTRL_OS  = 4'b0001;
  localparam logic [3:0]  CTRL_DAT = 4'b0000;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [7:0]  HDR_KIND_DATA = 8'h08;
  localparam logic [31:0] HDR_ACK  = 32'hC000_0000;

  // one 32-bit word folded into the CRC register, msb first
  function automatic logic [31:0] crc32_word(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/link_tx_crc.sv
module link_tx_crc
  import link_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed,
  input  logic        upd,
  input  logic [31:0] din,
  output logic [31:0] crc_word
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     crc_q <= CRC_SEED;
    else if (seed)  crc_q <= CRC_SEED;
    else if (upd)   crc_q <= crc32_word(crc_q, din);
  end

  assign crc_word = ~crc_q;

endmodule

// File: rtl/link_tx_req.sv
module link_tx_req #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_en,
  input  logic             data_en,
  input  logic [CNT_W-1:0] burst_frames,
  input  logic             ack_start,
  input  logic             ack_end,
  input  logic             data_end,
  output logic             ack_pend,
  output logic             data_pend,
  output logic [CNT_W-1:0] frm_idx,
  output logic             burst_done,
  output logic             ack_done
);

  logic             ack_q, data_q;
  logic             ack_rise, data_rise;
  logic [CNT_W-1:0] left_q;
  logic             idle_burst;

  assign ack_rise   = ack_en & ~ack_q;
  assign data_rise  = data_en & ~data_q;
  assign idle_burst = (left_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      data_q <= 1'b0;
    end else begin
      ack_q  <= ack_en;
      data_q <= data_en;
    end
  end

  // a new request wins over the start that consumes the older one
  always_ff @(posedge clk) begin
    if (!rst_n)         ack_pend <= 1'b0;
    else if (ack_rise)  ack_pend <= 1'b1;
    else if (ack_start) ack_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      frm_idx <= '0;
    end else if (data_end) begin
      left_q  <= left_q - 1'b1;
      frm_idx <= frm_idx + 1'b1;
    end else if (data_rise && idle_burst) begin
      left_q  <= burst_frames;
      frm_idx <= '0;
    end
  end

  assign data_pend  = ~idle_burst;
  assign burst_done = data_end && (left_q == {{(CNT_W-1){1'b0}}, 1'b1});
  assign ack_done   = ack_end;

endmodule

// File: rtl/link_tx_framer.sv
module link_tx_framer
  import link_tx_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int CNT_W   = 8,
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_pend,
  input  logic             data_pend,
  input  logic [CNT_W-1:0] frm_idx,
  input  logic [LEN_W-1:0] frame_words,
  input  logic [31:0]      buf_data,
  input  logic             buf_valid,
  output logic             buf_ready,
  output logic [31:0]      tx_data,
  output logic [3:0]       tx_ctrl,
  output logic             tx_valid,
  input  logic             tx_ready,
  input  logic [31:0]      crc_word,
  output logic             crc_seed,
  output logic             crc_upd,
  output logic             ack_start,
  output logic             ack_end,
  output logic             data_end
);

  localparam int GAP_W = $clog2(MIN_GAP + 2);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(MIN_GAP);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(MIN_GAP - 1);

  fr_state_e        state;
  logic             is_ack;
  logic [LEN_W-1:0] pay_left;
  logic [GAP_W-1:0] gap_cnt;
  logic             adv, go;
  logic [31:0]      hdr_word;

  assign adv      = tx_valid & tx_ready;
  assign go       = (gap_cnt >= GAP_LAST) && (ack_pend || data_pend);
  assign hdr_word = is_ack ? HDR_ACK : {HDR_KIND_DATA, 8'h00, 16'(frm_idx)};

  always_comb begin
    tx_data   = OS_IDLE;
    tx_ctrl   = CTRL_OS;
    tx_valid  = 1'b1;
    buf_ready = 1'b0;
    case (state)
      ST_SOF: tx_data = OS_SOF;
      ST_HDR: begin
        tx_data = hdr_word;
        tx_ctrl = CTRL_DAT;
      end
      ST_PAY: begin
        tx_data   = buf_data;
        tx_ctrl   = CTRL_DAT;
        tx_valid  = buf_valid;
        buf_ready = tx_ready;
      end
      ST_CRC: begin
        tx_data = crc_word;
        tx_ctrl = CTRL_DAT;
      end
      ST_EOF:  tx_data = OS_EOF;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      is_ack   <= 1'b0;
      pay_left <= '0;
      gap_cnt  <= '0;
    end else if (adv) begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state    <= ST_SOF;
            is_ack   <= ack_pend;
            pay_left <= frame_words;
          end else if (gap_cnt != GAP_FULL) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SOF: state <= ST_HDR;
        ST_HDR: state <= (is_ack || pay_left == '0) ? ST_CRC : ST_PAY;
        ST_PAY: begin
          pay_left <= pay_left - 1'b1;
          if (pay_left == {{(LEN_W-1){1'b0}}, 1'b1}) state <= ST_CRC;
        end
        ST_CRC: state <= ST_EOF;
        ST_EOF: begin
          state   <= ST_IDLE;
          gap_cnt <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign crc_seed  = adv && (state == ST_SOF);
  assign crc_upd   = adv && (state == ST_HDR || state == ST_PAY);
  assign ack_start = adv && (state == ST_IDLE) && go && ack_pend;
  assign ack_end   = adv && (state == ST_EOF) && is_ack;
  assign data_end  = adv && (state == ST_EOF) && !is_ack;

endmodule

// File: rtl/link_tx_scheduler.sv
module link_tx_scheduler
  import link_tx_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int CNT_W   = 8,
  parameter int MIN_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_en,
  input  logic             data_en,
  input  logic [CNT_W-1:0] burst_frames,
  input  logic [LEN_W-1:0] frame_words,
  input  logic [31:0]      buf_data,
  input  logic             buf_valid,
  output logic             buf_ready,
  output logic [31:0]      tx_data,
  output logic [3:0]       tx_ctrl,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             burst_done,
  output logic             ack_done
);

  logic             ack_pend, data_pend;
  logic [CNT_W-1:0] frm_idx;
  logic             ack_start, ack_end, data_end;
  logic             crc_seed, crc_upd;
  logic [31:0]      crc_word;

  link_tx_req #(.CNT_W(CNT_W)) u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .ack_en       (ack_en),
    .data_en      (data_en),
    .burst_frames (burst_frames),
    .ack_start    (ack_start),
    .ack_end      (ack_end),
    .data_end     (data_end),
    .ack_pend     (ack_pend),
    .data_pend    (data_pend),
    .frm_idx      (frm_idx),
    .burst_done   (burst_done),
    .ack_done     (ack_done)
  );

  link_tx_framer #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MIN_GAP(MIN_GAP)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_pend    (ack_pend),
    .data_pend   (data_pend),
    .frm_idx     (frm_idx),
    .frame_words (frame_words),
    .buf_data    (buf_data),
    .buf_valid   (buf_valid),
    .buf_ready   (buf_ready),
    .tx_data     (tx_data),
    .tx_ctrl     (tx_ctrl),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .crc_word    (crc_word),
    .crc_seed    (crc_seed),
    .crc_upd     (crc_upd),
    .ack_start   (ack_start),
    .ack_end     (ack_end),
    .data_end    (data_end)
  );

  link_tx_crc u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed     (crc_seed),
    .upd      (crc_upd),
    .din      (tx_data),
    .crc_word (crc_word)
  );

endmodule

// File: rtl/link_tx_scheduler_chk.sv
module link_tx_scheduler_chk
  import link_tx_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        buf_ready,
  input logic [31:0] tx_data,
  input logic [3:0]  tx_ctrl,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        burst_done,
  input logic        ack_done
);

  logic       hs, sof_hs, eof_hs, idle_hs;
  logic       in_frame;
  logic [7:0] idle_run;

  assign hs      = tx_valid && tx_ready;
  assign sof_hs  = hs && tx_ctrl == CTRL_OS && tx_data == OS_SOF;
  assign eof_hs  = hs && tx_ctrl == CTRL_OS && tx_data == OS_EOF;
  assign idle_hs = hs && tx_ctrl == CTRL_OS && tx_data == OS_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      idle_run <= '0;
    end else begin
      if (sof_hs) in_frame <= 1'b1;
      else if (eof_hs) in_frame <= 1'b0;
      if (eof_hs) idle_run <= '0;
      else if (idle_hs && idle_run != 8'hFF) idle_run <= idle_run + 1'b1;
    end
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_ctrl)));

  // R9
  buf_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ready |-> tx_ready);

  // R9
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> tx_ctrl == CTRL_DAT);

  // R5
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({burst_done, ack_done}));

  // R6
  done_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_done || ack_done) |-> eof_hs);

  // R8
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_hs |-> (int'(idle_run) >= MIN_GAP));

  // R2
  sof_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_hs |-> !in_frame);

  // R2
  eof_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_hs |-> in_frame);

endmodule

bind link_tx_scheduler link_tx_scheduler_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .buf_ready  (buf_ready),
  .tx_data    (tx_data),
  .tx_ctrl    (tx_ctrl),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .burst_done (burst_done),
  .ack_done   (ack_done)
);

// File: tb/tb_link_tx_scheduler.sv
module tb_link_tx_scheduler;

  localparam logic [31:0] W_IDLE = 32'hB595_95BC;
  localparam logic [31:0] W_SOF  = 32'h3636_B5BC;
  localparam logic [31:0] W_EOF  = 32'h9595_75BC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_en = 1'b0, data_en = 1'b0;
  logic [7:0]  burst_frames = 8'd0, frame_words = 8'd0;
  logic [31:0] buf_data;
  logic        buf_valid = 1'b0, buf_ready;
  logic [31:0] tx_data;
  logic [3:0]  tx_ctrl;
  logic        tx_valid, tx_ready = 1'b1;
  logic        burst_done, ack_done;

  int checks = 0, fails = 0;

  link_tx_scheduler dut (
    .clk(clk), .rst_n(rst_n), .ack_en(ack_en), .data_en(data_en),
    .burst_frames(burst_frames), .frame_words(frame_words),
    .buf_data(buf_data), .buf_valid(buf_valid), .buf_ready(buf_ready),
    .tx_data(tx_data), .tx_ctrl(tx_ctrl), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .burst_done(burst_done), .ack_done(ack_done)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [31:0] hdr;
    int          len;
    bit          last;
    bit          ack;
  } exp_t;

  exp_t  exp_q[$];
  string cur_tag = "R4";

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] bufval(input int k);
    logic [31:0] kk;
    kk = k;
    return (kk * 32'h0101_0103) ^ 32'hA000_0000;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [31:0] w[$], input int n);
    logic [31:0] r;
    logic        b;
    r = 32'hFFFF_FFFF;
    for (int j = 0; j < n; j++)
      for (int k = 31; k >= 0; k--) begin
        b = r[31] ^ w[j][k];
        r = r << 1;
        if (b) r = r ^ 32'h04C1_1DB7;
      end
    return ~r;
  endfunction

  // ---------------- stream driver ----------------
  bit        stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int        rd_idx = 0;
  bit        buf_hs = 1'b0;

  assign buf_data = bufval(rd_idx);

  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (buf_hs) rd_idx++;
      if (buf_hs || !buf_valid) buf_valid = stall ? (lfsr[5] | lfsr[7]) : 1'b1;
      tx_ready = stall ? (lfsr[0] | lfsr[3]) : 1'b1;
      #1;
      buf_hs = buf_valid && buf_ready && rst_n;
    end
  end

  // ---------------- monitor / scoreboard ----------------
  bit          mon_in = 1'b0;
  int          gap = 0, frames_seen = 0, idles_seen = 0, mon_pidx = 0;
  logic [31:0] fw[$];
  bit          hold_pend = 1'b0;
  logic [31:0] hold_word;
  bit          bad_ctrl;

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (hold_pend)
          chk(tx_valid && tx_data == hold_word, "R9 hold", tx_data, hold_word);
        hold_pend = tx_valid && !tx_ready;
        hold_word = tx_data;
        if (buf_ready && !tx_ready) chk(1'b0, "R9 buf_ready", 32'(buf_ready), 32'(tx_ready));
        if ((burst_done || ack_done) && !(tx_valid && tx_ready && tx_data == W_EOF))
          chk(1'b0, "R5 stray done", {burst_done, ack_done}, 32'h0);
        if (tx_valid && tx_ready) begin
          if (!mon_in) begin
            if (tx_data == W_IDLE && tx_ctrl == 4'b0001) begin
              gap++; idles_seen++;
            end else if (tx_data == W_SOF && tx_ctrl == 4'b0001) begin
              chk(gap >= 2, "R8 idle gap", gap, 2);
              mon_in = 1'b1; fw.delete(); bad_ctrl = 1'b0;
            end else begin
              chk(1'b0, "R1 non-idle outside frame", tx_data, W_IDLE);
            end
          end else if (tx_data == W_EOF && tx_ctrl == 4'b0001) begin
            mon_in = 1'b0; gap = 0; frames_seen++;
            if (exp_q.size() == 0) begin
              chk(1'b0, "R2 unexpected frame", fw[0], 32'h0);
            end else begin
              exp_t e;
              int n;
              e = exp_q.pop_front();
              n = fw.size();
              chk(!bad_ctrl, "R2 ctrl flags", 32'(bad_ctrl), 0);
              chk(n >= 2 && fw[0] == e.hdr, e.ack ? "R6 ack header" : cur_tag, fw[0], e.hdr);
              chk(n - 2 == e.len, "R2 payload length", n - 2, e.len);
              for (int p = 1; p < n - 1; p++) begin
                chk(fw[p] == bufval(mon_pidx), "R2 payload word", fw[p], bufval(mon_pidx));
                mon_pidx++;
              end
              if (n >= 2) chk(fw[n-1] == ref_crc(fw, n - 1), "R3 crc", fw[n-1], ref_crc(fw, n - 1));
              chk(burst_done == e.last, "R5 burst_done", 32'(burst_done), 32'(e.last));
              chk(ack_done == e.ack, "R6 ack_done", 32'(ack_done), 32'(e.ack));
            end
          end else begin
            if (tx_ctrl != 4'b0000) bad_ctrl = 1'b1;
            fw.push_back(tx_data);
          end
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic push_burst(input int n, input int len);
    for (int i = 0; i < n; i++)
      exp_q.push_back('{hdr: {8'h08, 8'h00, 16'(i)}, len: len, last: (i == n - 1), ack: 1'b0});
  endtask

  task automatic push_ack();
    exp_q.push_back('{hdr: 32'hC000_0000, len: 0, last: 1'b0, ack: 1'b1});
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || mon_in) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic arm(input int n, input int len);
    @(negedge clk);
    data_en = 1'b0;
    repeat (2) @(negedge clk);
    burst_frames = 8'(n);
    frame_words  = 8'(len);
    data_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    #3;
    // R10 reset state
    chk(tx_valid && tx_data == W_IDLE && tx_ctrl == 4'b0001, "R10 reset word", tx_data, W_IDLE);
    chk(!buf_ready && !burst_done && !ack_done, "R10 reset outputs",
        {buf_ready, burst_done, ack_done}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 idle fill
    repeat (12) @(negedge clk);
    chk(frames_seen == 0 && idles_seen >= 10, "R1 idle fill", idles_seen, 10);

    // R4 plain burst
    cur_tag = "R4 data header";
    push_burst(3, 4);
    arm(3, 4);
    drain();

    // R9 short frames under stalls
    stall = 1'b1;
    push_burst(2, 1);
    arm(2, 1);
    drain();

    // R5 holding data_en high starts nothing
    snap = frames_seen;
    repeat (60) @(negedge clk);
    chk(frames_seen == snap, "R5 no re-arm while high", frames_seen, snap);

    // R2 header-only data frame after re-arm
    push_burst(1, 0);
    arm(1, 0);
    drain();

    // R6 lone acknowledge
    push_ack();
    @(negedge clk); ack_en = 1'b1;
    @(negedge clk); ack_en = 1'b0;
    drain();

    // R7 ack during a burst frame
    cur_tag = "R7 order";
    exp_q.push_back('{hdr: 32'h0800_0000, len: 6, last: 1'b0, ack: 1'b0});
    push_ack();
    exp_q.push_back('{hdr: 32'h0800_0001, len: 6, last: 1'b0, ack: 1'b0});
    exp_q.push_back('{hdr: 32'h0800_0002, len: 6, last: 1'b1, ack: 1'b0});
    arm(3, 6);
    while (!mon_in) @(negedge clk);
    ack_en = 1'b1;
    @(negedge clk); ack_en = 1'b0;
    // R5 edge during active burst ignored
    burst_frames = 8'd9;
    data_en = 1'b0;
    @(negedge clk); data_en = 1'b1;
    drain();
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0 && !mon_in, "R5 mid-burst edge ignored", exp_q.size(), 0);

    // R4 zero count sends nothing
    stall = 1'b0;
    snap = frames_seen;
    arm(0, 3);
    repeat (40) @(negedge clk);
    chk(frames_seen == snap, "R4 zero count", frames_seen, snap);

    finish_run();
  end

endmodule